// File: doc/BRIEF.md
# Two-Way Time Offset Calculator

This block turns the four timestamps of one two-way time-transfer exchange into a mean path delay and a clock offset. The slave receives a sync message and stamps its arrival locally. It sends a delay request and stamps its departure locally. Two more times come from the master: the time the sync left the master, which is delivered late in a follow-up message, and the time the delay request reached the master. Each of the four times enters on its own port, with a valid strobe and a sequence tag.

The slave arrival of the sync opens an exchange and sets the reference tag. The other three times are accepted in any order after that, but only when their tag matches. Once all four are held, the block registers the signed mean path delay and the signed slave-minus-master offset and raises a single-cycle result strobe. The path is taken to be symmetric, so no asymmetry correction is applied. Timestamps are nanosecond counts whose width is a parameter (64 bits by default).

Top module: `tw_offset_calc`

## Requirements
- R1: While reset is asserted and after it is released, `res_vld` is 0 until an exchange completes.
- R2: With fwd = sync_rx − sync_tx and rev = dreq_rx − dreq_tx, each taken as a TS_W-bit two's-complement difference, `mean_delay` = floor((fwd + rev) / 2). The sum is formed one bit wider, so it cannot overflow, and no asymmetry term is applied.
- R3: `clk_offset` = fwd − `mean_delay`, as a TS_W-bit two's-complement value.
- R4: After the sync arrival is held, the sync departure time (follow-up), the request departure and the request arrival are accepted in any order. The sync departure may come last.
- R5: A strobe on sync_tx, dreq_tx or dreq_rx is ignored unless its tag equals the tag of the held sync arrival.
- R6: A strobe on sync_tx, dreq_tx or dreq_rx when no sync arrival is held is ignored.
- R7: A sync arrival strobe discards every partial capture and starts a new exchange with its own tag.
- R8: `res_vld` is high for exactly one cycle. It rises on the clock edge after the edge that captured the last of the four times. After the result all captures are cleared.
- R9: Within an exchange, the first accepted value on each of the three follower inputs is kept. Later strobes on that input are ignored.
- R10: A follower strobe in the same cycle as a sync arrival strobe is ignored.
- R11: `mean_delay` and `clk_offset` keep their last values between result strobes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sync_tx_vld | input | 1 | Master sync departure time valid (follow-up) |
| sync_tx_tag | input | TAG_W | Sequence tag of the sync departure time |
| sync_tx_ts | input | TS_W | Master sync departure time |
| sync_rx_vld | input | 1 | Slave sync arrival time valid; opens an exchange |
| sync_rx_tag | input | TAG_W | Sequence tag of the sync arrival |
| sync_rx_ts | input | TS_W | Slave sync arrival time |
| dreq_tx_vld | input | 1 | Slave delay-request departure time valid |
| dreq_tx_tag | input | TAG_W | Sequence tag of the request departure |
| dreq_tx_ts | input | TS_W | Slave delay-request departure time |
| dreq_rx_vld | input | 1 | Master delay-request arrival time valid |
| dreq_rx_tag | input | TAG_W | Sequence tag of the request arrival |
| dreq_rx_ts | input | TS_W | Master delay-request arrival time |
| res_vld | output | 1 | One-cycle result strobe |
| mean_delay | output | TS_W | Signed mean path delay |
| clk_offset | output | TS_W | Signed slave-minus-master offset |

## Verification
The bench sends the late follow-up time after both request times. A design that insists on a fixed arrival order would never produce a result for that exchange. It also uses a negative odd sum to check rounding: truncation toward zero gives −1 where −2 is expected. A near-full-scale pair of differences checks the guard bit, and a dropped guard bit shows up as a negative delay. Further tests cover mismatched tags, strobes before a sync, strobes coincident with a sync, a second sync in mid-exchange and repeated follower strobes. A design that lets any of these through either completes an exchange that should be incomplete or reports values built from the wrong capture.

// File: rtl/tw_pkg.sv
package tw_pkg;
  typedef enum int unsigned {
    FOL_SYNC_TX = 0,
    FOL_DREQ_TX = 1,
    FOL_DREQ_RX = 2
  } fol_idx_e;

  localparam int unsigned FOL_N = 3;
endpackage

// File: rtl/tw_stamp_slot.sv
module tw_stamp_slot #(
  parameter int unsigned TS_W  = 64,
  parameter int unsigned TAG_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             done,
  input  logic             armed,
  input  logic [TAG_W-1:0] ref_tag,
  input  logic             in_vld,
  input  logic [TAG_W-1:0] in_tag,
  input  logic [TS_W-1:0]  in_ts,
  output logic             held,
  output logic [TS_W-1:0]  ts_q
);
  logic            accept;
  logic            held_d;
  logic [TS_W-1:0] ts_d;

  always_comb begin
    accept = in_vld && armed && !start && !held && (in_tag == ref_tag);
    if (start || done) held_d = 1'b0;
    else               held_d = held || accept;
    ts_d = accept ? in_ts : ts_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held <= 1'b0;
      ts_q <= '0;
    end else begin
      held <= held_d;
      ts_q <= ts_d;
    end
  end

  a_r9_first_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (held && !start && !done) |=> $stable(ts_q));
  a_r5_tag_match: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(held) |-> ($past(in_tag) == $past(ref_tag)));
  a_r6_needs_sync: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(held) |-> $past(armed));
  a_r10_not_with_sync: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> !held);
endmodule

// File: rtl/tw_delay_math.sv
module tw_delay_math #(
  parameter int unsigned TS_W = 64
) (
  input  logic [TS_W-1:0] t_sync_tx,
  input  logic [TS_W-1:0] t_sync_rx,
  input  logic [TS_W-1:0] t_dreq_tx,
  input  logic [TS_W-1:0] t_dreq_rx,
  output logic [TS_W-1:0] delay,
  output logic [TS_W-1:0] offset
);
  localparam int unsigned SUM_W = TS_W + 1;

  logic signed [TS_W-1:0]  fwd;
  logic signed [TS_W-1:0]  rev;
  logic signed [SUM_W-1:0] sum;
  logic signed [SUM_W-1:0] half;

  always_comb begin
    fwd    = $signed(t_sync_rx - t_sync_tx);
    rev    = $signed(t_dreq_rx - t_dreq_tx);
    sum    = SUM_W'(fwd) + SUM_W'(rev);
    half   = sum >>> 1;
    delay  = half[TS_W-1:0];
    offset = fwd - delay;
  end
endmodule

// File: rtl/tw_offset_calc.sv
module tw_offset_calc
  import tw_pkg::*;
#(
  parameter int unsigned TS_W  = 64,
  parameter int unsigned TAG_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sync_tx_vld,
  input  logic [TAG_W-1:0] sync_tx_tag,
  input  logic [TS_W-1:0]  sync_tx_ts,
  input  logic             sync_rx_vld,
  input  logic [TAG_W-1:0] sync_rx_tag,
  input  logic [TS_W-1:0]  sync_rx_ts,
  input  logic             dreq_tx_vld,
  input  logic [TAG_W-1:0] dreq_tx_tag,
  input  logic [TS_W-1:0]  dreq_tx_ts,
  input  logic             dreq_rx_vld,
  input  logic [TAG_W-1:0] dreq_rx_tag,
  input  logic [TS_W-1:0]  dreq_rx_ts,
  output logic             res_vld,
  output logic [TS_W-1:0]  mean_delay,
  output logic [TS_W-1:0]  clk_offset
);
  logic [FOL_N-1:0] f_vld;
  logic [TAG_W-1:0] f_tag  [FOL_N];
  logic [TS_W-1:0]  f_ts   [FOL_N];
  logic [FOL_N-1:0] f_held;
  logic [TS_W-1:0]  f_q    [FOL_N];

  logic             anc_held, anc_held_d;
  logic [TAG_W-1:0] anc_tag,  anc_tag_d;
  logic [TS_W-1:0]  anc_ts,   anc_ts_d;
  logic             complete;
  logic             res_vld_d;
  logic [TS_W-1:0]  delay_c, offset_c;
  logic [TS_W-1:0]  delay_d, offset_d;

  always_comb begin
    f_vld[FOL_SYNC_TX] = sync_tx_vld;
    f_vld[FOL_DREQ_TX] = dreq_tx_vld;
    f_vld[FOL_DREQ_RX] = dreq_rx_vld;
    f_tag[FOL_SYNC_TX] = sync_tx_tag;
    f_tag[FOL_DREQ_TX] = dreq_tx_tag;
    f_tag[FOL_DREQ_RX] = dreq_rx_tag;
    f_ts[FOL_SYNC_TX]  = sync_tx_ts;
    f_ts[FOL_DREQ_TX]  = dreq_tx_ts;
    f_ts[FOL_DREQ_RX]  = dreq_rx_ts;
  end

  assign complete = anc_held && (&f_held);

  genvar gi;
  generate
    for (gi = 0; gi < FOL_N; gi++) begin : g_fol
      tw_stamp_slot #(.TS_W(TS_W), .TAG_W(TAG_W)) u_slot (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (sync_rx_vld),
        .done    (complete),
        .armed   (anc_held),
        .ref_tag (anc_tag),
        .in_vld  (f_vld[gi]),
        .in_tag  (f_tag[gi]),
        .in_ts   (f_ts[gi]),
        .held    (f_held[gi]),
        .ts_q    (f_q[gi])
      );
    end
  endgenerate

  tw_delay_math #(.TS_W(TS_W)) u_math (
    .t_sync_tx (f_q[FOL_SYNC_TX]),
    .t_sync_rx (anc_ts),
    .t_dreq_tx (f_q[FOL_DREQ_TX]),
    .t_dreq_rx (f_q[FOL_DREQ_RX]),
    .delay     (delay_c),
    .offset    (offset_c)
  );

  always_comb begin
    anc_held_d = anc_held;
    anc_tag_d  = anc_tag;
    anc_ts_d   = anc_ts;
    if (sync_rx_vld) begin
      anc_held_d = 1'b1;
      anc_tag_d  = sync_rx_tag;
      anc_ts_d   = sync_rx_ts;
    end else if (complete) begin
      anc_held_d = 1'b0;
    end
    res_vld_d = complete;
    delay_d   = complete ? delay_c  : mean_delay;
    offset_d  = complete ? offset_c : clk_offset;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      anc_held   <= 1'b0;
      anc_tag    <= '0;
      anc_ts     <= '0;
      res_vld    <= 1'b0;
      mean_delay <= '0;
      clk_offset <= '0;
    end else begin
      anc_held   <= anc_held_d;
      anc_tag    <= anc_tag_d;
      anc_ts     <= anc_ts_d;
      res_vld    <= res_vld_d;
      mean_delay <= delay_d;
      clk_offset <= offset_d;
    end
  end

  a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    res_vld |=> !res_vld);
  a_r8_after_full_set: assert property (@(posedge clk) disable iff (!rst_n)
    res_vld |-> ($past(anc_held) && $past(&f_held)));
  a_r7_sync_clears: assert property (@(posedge clk) disable iff (!rst_n)
    sync_rx_vld |=> (f_held == '0));
  a_r11_hold_values: assert property (@(posedge clk) disable iff (!rst_n)
    !res_vld |-> ($stable(mean_delay) && $stable(clk_offset)));
endmodule

// File: tb/tw_offset_calc_tb.sv
module tw_offset_calc_tb;
  localparam int TS_W  = 64;
  localparam int TAG_W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic             sync_tx_vld = 0, sync_rx_vld = 0, dreq_tx_vld = 0, dreq_rx_vld = 0;
  logic [TAG_W-1:0] sync_tx_tag = 0, sync_rx_tag = 0, dreq_tx_tag = 0, dreq_rx_tag = 0;
  logic [TS_W-1:0]  sync_tx_ts = 0, sync_rx_ts = 0, dreq_tx_ts = 0, dreq_rx_ts = 0;
  logic             res_vld;
  logic [TS_W-1:0]  mean_delay, clk_offset;

  int n_chk = 0;
  int n_fail = 0;
  int pulses = 0;

  always #2.5 clk = ~clk;

  tw_offset_calc #(.TS_W(TS_W), .TAG_W(TAG_W)) u_dut (.*);

  always @(negedge clk) if (rst_n && res_vld) pulses++;

  task automatic chk(input bit ok, input string req, input logic [TS_W-1:0] act, input logic [TS_W-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // which: 1=sync_tx 2=sync_rx 3=dreq_tx 4=dreq_rx; strobe lasts one cycle
  task automatic put(input int which, input logic [TS_W-1:0] ts, input logic [TAG_W-1:0] tag);
    @(negedge clk);
    case (which)
      1: begin sync_tx_vld = 1; sync_tx_ts = ts; sync_tx_tag = tag; end
      2: begin sync_rx_vld = 1; sync_rx_ts = ts; sync_rx_tag = tag; end
      3: begin dreq_tx_vld = 1; dreq_tx_ts = ts; dreq_tx_tag = tag; end
      default: begin dreq_rx_vld = 1; dreq_rx_ts = ts; dreq_rx_tag = tag; end
    endcase
    @(negedge clk);
    sync_tx_vld = 0; sync_rx_vld = 0; dreq_tx_vld = 0; dreq_rx_vld = 0;
  endtask

  function automatic logic [TS_W-1:0] exp_delay(logic [TS_W-1:0] a, b, c, d);
    logic signed [TS_W+1:0] s;
    s = $signed({{2{(b - a) >> (TS_W-1)}}, 1'b0} >> 1);
    s = (TS_W+2)'($signed(b - a)) + (TS_W+2)'($signed(d - c));
    return TS_W'(s >>> 1);
  endfunction

  // call right after the last put: result visible at this negedge
  task automatic expect_result(input string req, input logic [TS_W-1:0] a, b, c, d);
    logic [TS_W-1:0] ed, eo;
    ed = exp_delay(a, b, c, d);
    eo = (b - a) - ed;
    @(negedge clk);
    chk(res_vld === 1'b1, {req, " R8 pulse"}, TS_W'(res_vld), 1);
    chk(mean_delay === ed, {req, " R2 delay"}, mean_delay, ed);
    chk(clk_offset === eo, {req, " R3 offset"}, clk_offset, eo);
    @(negedge clk);
    chk(res_vld === 1'b0, {req, " R8 one cycle"}, TS_W'(res_vld), 0);
    chk(mean_delay === ed, {req, " R11 hold"}, mean_delay, ed);
  endtask

  task automatic expect_quiet(input string req, input int p0);
    repeat (3) @(negedge clk);
    chk(pulses == p0, req, TS_W'(pulses), TS_W'(p0));
  endtask

  task automatic t_reset();
    chk(res_vld === 1'b0, "R1 reset", TS_W'(res_vld), 0);
  endtask

  task automatic t_basic();
    put(2, 1600, 1); put(1, 1000, 1); put(3, 2000, 1); put(4, 2400, 1);
    expect_result("basic", 1000, 1600, 2000, 2400);
  endtask

  task automatic t_late_followup();
    put(2, 5100, 2); put(3, 6000, 2); put(4, 6300, 2); put(1, 5000, 2);
    expect_result("R4 late follow-up", 5000, 5100, 6000, 6300);
  endtask

  task automatic t_neg_odd();
    put(2, 995, 3); put(1, 1000, 3); put(3, 10, 3); put(4, 12, 3);
    expect_result("R2 neg odd floor", 1000, 995, 10, 12);
  endtask

  task automatic t_guard();
    logic [TS_W-1:0] m = {1'b0, {(TS_W-1){1'b1}}};
    put(2, m, 4); put(1, 0, 4); put(3, 0, 4); put(4, m, 4);
    expect_result("R2 guard bit", 0, m, 0, m);
  endtask

  task automatic t_tag_mismatch();
    int p0 = pulses;
    put(2, 300, 9); put(1, 100, 8); put(3, 400, 9); put(4, 500, 9);
    expect_quiet("R5 mismatched tag ignored", p0);
    put(1, 200, 9);
    expect_result("R5 matched tag", 200, 300, 400, 500);
  endtask

  task automatic t_no_sync();
    int p0 = pulses;
    put(1, 10, 5); put(3, 20, 5); put(4, 30, 5);
    put(2, 40, 5);
    expect_quiet("R6 strobes before sync ignored", p0);
    put(1, 11, 5); put(3, 50, 5); put(4, 90, 5);
    expect_result("R6 after sync", 11, 40, 50, 90);
  endtask

  task automatic t_resync();
    int p0 = pulses;
    put(2, 700, 6); put(1, 600, 6); put(3, 800, 6);
    put(2, 1700, 7); put(4, 1900, 7);
    expect_quiet("R7 partial set cleared", p0);
    put(1, 1550, 7); put(3, 1800, 7);
    expect_result("R7 new exchange", 1550, 1700, 1800, 1900);
  endtask

  task automatic t_first_wins();
    put(2, 3000, 10); put(1, 2900, 10); put(1, 2000, 10); put(3, 3100, 10); put(4, 3150, 10);
    expect_result("R9 first kept", 2900, 3000, 3100, 3150);
  endtask

  task automatic t_same_cycle();
    int p0 = pulses;
    @(negedge clk);
    sync_rx_vld = 1; sync_rx_ts = 8000; sync_rx_tag = 11;
    sync_tx_vld = 1; sync_tx_ts = 7000; sync_tx_tag = 11;
    @(negedge clk);
    sync_rx_vld = 0; sync_tx_vld = 0;
    put(3, 9000, 11); put(4, 9100, 11);
    expect_quiet("R10 coincident strobe ignored", p0);
    put(1, 7900, 11);
    expect_result("R10 later strobe", 7900, 8000, 9000, 9100);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_basic();
        t_late_followup();
        t_neg_odd();
        t_guard();
        t_tag_mismatch();
        t_no_sync();
        t_resync();
        t_first_wins();
        t_same_cycle();
      end
      begin
        repeat (20000) @(negedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=hung expected=done");
      end
    join_any
    disable fork;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule